// File: doc/BRIEF.md
# In-Run Sequential Memory Update Scheduler

This block commits a staged burst of 1 to 16 words into a coefficient memory while a signal-processing program keeps running over that memory. The host presents a start address, a word count and the word data, then pulses an execute strobe. The block copies the burst into an internal staging buffer and waits. It writes a word only in the cycle in which the running program itself accesses that word's address. The program therefore never sees a half-updated coefficient in the middle of its own pass.

Pending words are handled strictly in ascending address order. Only the word at the head of the list can be written. An access to any later pending address is treated as a wait and has no effect. A ready output stays low from the accepted execute until the final word has gone out. After the final write the block returns to idle, invalidates the staging buffer and raises ready.

Top module: `mem_update_sched`

## Requirements
- R1: After reset, ready is 1 and wr_en is 0.
- R2: wr_en is 1 only in a cycle where acc_valid is 1 and acc_addr equals the address of the head pending word. In that cycle wr_addr equals acc_addr, and wr_data is the staged word at offset k, where k is the head address minus the start address. Word k occupies stage_data bits [24k+23:24k].
- R3: Words are written in ascending address order from the start address. An access to a pending address other than the head produces no write and does not advance the list.
- R4: ready is 0 from the clock edge that accepts an execute strobe until the clock edge that ends the cycle of the final write. It is 1 from that edge on.
- R5: The burst length is stage_count + 1. stage_count is 4 bits, so the length is 1 to 16 words.
- R6: An execute strobe while ready is 0 is ignored. This includes a strobe in the cycle of the final write. Neither the pending list nor the staged data changes.
- R7: While ready is 1, no access produces a write, including accesses to addresses of the completed burst.
- R8: Pending addresses are computed modulo 2^16, so a burst that starts near the top of the address space continues at address 0.
- R9: An access with acc_valid at 0 produces no write, even if acc_addr matches the head address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exec_strobe | input | 1 | Starts an update with the staged inputs when idle |
| stage_addr | input | 16 | First address of the burst |
| stage_count | input | 4 | Burst length minus one |
| stage_data | input | 384 | Sixteen 24-bit words, word k in bits [24k+23:24k] |
| acc_valid | input | 1 | Program access valid this cycle |
| acc_addr | input | 16 | Address the program is accessing |
| wr_en | output | 1 | Memory write enable, one cycle per word |
| wr_addr | output | 16 | Memory write address |
| wr_data | output | 24 | Memory write data |
| ready | output | 1 | High when no update is in progress |

## Verification
The program can reach the final pending address in the same cycle that the host pulses execute again. In that cycle, completing the burst competes with starting a new one. The bench provokes this by driving the strobe together with the final matching access, with a fresh start address on the staging inputs. It judges the result by three observations: the final word must still be written with the old data, ready must rise on the next edge, and a later access to the fresh address must produce no write.

// File: rtl/mus_pkg.sv
package mus_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } mus_state_e;
endpackage

// File: rtl/mus_rst_sync.sv
module mus_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/mus_stage_buf.sv
module mus_stage_buf #(
  parameter int DATA_W = 24,
  parameter int DEPTH  = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load,
  input  logic                    clear,
  input  logic [DEPTH*DATA_W-1:0] din_flat,
  input  logic [IDX_W-1:0]        rd_idx,
  output logic [DATA_W-1:0]       rd_word,
  output logic                    valid
);
  logic [DATA_W-1:0] word_q [DEPTH];
  logic              valid_q, valid_d;

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    word_q[gi] <= '0;
      else if (load) word_q[gi] <= din_flat[gi*DATA_W +: DATA_W];
    end
  end

  always_comb begin
    valid_d = valid_q;
    if (clear)     valid_d = 1'b0;
    else if (load) valid_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= valid_d;
  end

  assign rd_word = word_q[rd_idx];
  assign valid   = valid_q;
endmodule

// File: rtl/mus_ptr.sv
module mus_ptr #(
  parameter int ADDR_W = 16,
  parameter int DEPTH  = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [IDX_W-1:0]  last_idx,
  input  logic              adv,
  output logic [IDX_W-1:0]  idx,
  output logic [ADDR_W-1:0] head_addr,
  output logic              is_last
);
  logic [ADDR_W-1:0] base_q, base_d;
  logic [IDX_W-1:0]  idx_q, idx_d, last_q, last_d;
  logic              en;

  always_comb begin
    base_d = base_q;
    last_d = last_q;
    idx_d  = idx_q;
    if (load) begin
      base_d = start_addr;
      last_d = last_idx;
      idx_d  = '0;
    end else if (adv) begin
      idx_d  = idx_q + IDX_W'(1);
    end
  end

  assign en = load | adv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      last_q <= '0;
      idx_q  <= '0;
    end else if (en) begin
      base_q <= base_d;
      last_q <= last_d;
      idx_q  <= idx_d;
    end
  end

  assign idx       = idx_q;
  assign head_addr = base_q + ADDR_W'(idx_q);
  assign is_last   = (idx_q == last_q);
endmodule

// File: rtl/mus_ctrl.sv
module mus_ctrl
  import mus_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic exec_strobe,
  input  logic hit,
  input  logic is_last,
  output logic load,
  output logic clear,
  output logic busy
);
  mus_state_e st_q, st_d;

  always_comb begin
    st_d  = st_q;
    load  = 1'b0;
    clear = 1'b0;
    unique case (st_q)
      ST_IDLE: if (exec_strobe) begin
        load = 1'b1;
        st_d = ST_RUN;
      end
      ST_RUN: if (hit && is_last) begin
        clear = 1'b1;
        st_d  = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  assign busy = (st_q == ST_RUN);
endmodule

// File: rtl/mem_update_sched.sv
module mem_update_sched #(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 24,
  parameter int MAX_WORDS = 16,
  localparam int CNT_W    = $clog2(MAX_WORDS)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        exec_strobe,
  input  logic [ADDR_W-1:0]           stage_addr,
  input  logic [CNT_W-1:0]            stage_count,
  input  logic [MAX_WORDS*DATA_W-1:0] stage_data,
  input  logic                        acc_valid,
  input  logic [ADDR_W-1:0]           acc_addr,
  output logic                        wr_en,
  output logic [ADDR_W-1:0]           wr_addr,
  output logic [DATA_W-1:0]           wr_data,
  output logic                        ready
);
  logic              rst_i_n;
  logic              load, clear, busy, hit, is_last, buf_valid;
  logic [CNT_W-1:0]  idx;
  logic [ADDR_W-1:0] head_addr;

  mus_rst_sync u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i_n)
  );

  mus_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_i_n), .exec_strobe(exec_strobe),
    .hit(hit), .is_last(is_last),
    .load(load), .clear(clear), .busy(busy)
  );

  mus_ptr #(.ADDR_W(ADDR_W), .DEPTH(MAX_WORDS)) u_ptr (
    .clk(clk), .rst_n(rst_i_n), .load(load),
    .start_addr(stage_addr), .last_idx(stage_count),
    .adv(hit), .idx(idx), .head_addr(head_addr), .is_last(is_last)
  );

  mus_stage_buf #(.DATA_W(DATA_W), .DEPTH(MAX_WORDS)) u_buf (
    .clk(clk), .rst_n(rst_i_n), .load(load), .clear(clear),
    .din_flat(stage_data), .rd_idx(idx),
    .rd_word(wr_data), .valid(buf_valid)
  );

  assign hit     = busy & buf_valid & acc_valid & (acc_addr == head_addr);
  assign wr_en   = hit;
  assign wr_addr = head_addr;
  assign ready   = ~busy;
endmodule

// File: rtl/mus_checker.sv
module mus_checker #(
  parameter int ADDR_W    = 16,
  parameter int MAX_WORDS = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              exec_strobe,
  input logic              acc_valid,
  input logic [ADDR_W-1:0] acc_addr,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              ready
);
  logic              have_last;
  logic [ADDR_W-1:0] last_wa;
  logic [5:0]        wcount;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_last <= 1'b0;
      last_wa   <= '0;
      wcount    <= '0;
    end else if (wr_en) begin
      have_last <= 1'b1;
      last_wa   <= wr_addr;
      wcount    <= wcount + 6'd1;
    end else if (ready) begin
      have_last <= 1'b0;
      wcount    <= '0;
    end
  end

  AST_WRITE_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (acc_valid && acc_addr == wr_addr)); // R2
  AST_ASCENDING: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && have_last) |-> (wr_addr == last_wa + ADDR_W'(1))); // R3
  AST_READY_FALLS: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && exec_strobe) |=> !ready); // R4
  AST_BURST_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    wcount <= 6'(MAX_WORDS)); // R5
  AST_EXEC_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready && exec_strobe && !wr_en) |=> !ready); // R6
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> !wr_en); // R7
  AST_VALID_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |-> !wr_en); // R9
endmodule

bind mem_update_sched mus_checker #(.ADDR_W(ADDR_W), .MAX_WORDS(MAX_WORDS)) u_chk (
  .clk(clk), .rst_n(rst_n), .exec_strobe(exec_strobe),
  .acc_valid(acc_valid), .acc_addr(acc_addr),
  .wr_en(wr_en), .wr_addr(wr_addr), .ready(ready)
);

// File: tb/mem_update_sched_tb.sv
module mem_update_sched_tb;
  localparam int AW = 16, DW = 24, NW = 16;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           exec_strobe, acc_valid;
  logic [AW-1:0]  stage_addr, acc_addr, wr_addr;
  logic [3:0]     stage_count;
  logic [NW*DW-1:0] stage_data;
  logic           wr_en, ready;
  logic [DW-1:0]  wr_data;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  mem_update_sched u_dut (
    .clk(clk), .rst_n(rst_n), .exec_strobe(exec_strobe),
    .stage_addr(stage_addr), .stage_count(stage_count), .stage_data(stage_data),
    .acc_valid(acc_valid), .acc_addr(acc_addr),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .ready(ready)
  );

  // {valid, addr, expect write, expected word offset}; burst at 10, 5 words
  localparam logic [21:0] VEC [12] = '{
    {1'b1, 16'd7,  1'b0, 4'd0}, {1'b1, 16'd8,  1'b0, 4'd0},
    {1'b1, 16'd9,  1'b0, 4'd0}, {1'b1, 16'd10, 1'b1, 4'd0},
    {1'b1, 16'd11, 1'b1, 4'd1}, {1'b1, 16'd13, 1'b0, 4'd0},
    {1'b1, 16'd16, 1'b0, 4'd0}, {1'b1, 16'd11, 1'b0, 4'd0},
    {1'b1, 16'd12, 1'b1, 4'd2}, {1'b1, 16'd13, 1'b1, 4'd3},
    {1'b1, 16'd14, 1'b1, 4'd4}, {1'b1, 16'd15, 1'b0, 4'd0}
  };

  function automatic logic [DW-1:0] wv(input logic [7:0] salt, input int i);
    return {salt, 8'hA5, 4'h0, 4'(i)};
  endfunction

  task automatic chk(input string tag, input logic ok, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic stage(input logic [AW-1:0] a, input logic [3:0] c, input logic [7:0] salt);
    stage_addr  = a;
    stage_count = c;
    for (int i = 0; i < NW; i++) stage_data[i*DW +: DW] = wv(salt, i);
  endtask

  task automatic go();
    @(negedge clk);
    acc_valid   = 1'b0;
    exec_strobe = 1'b1;
    @(posedge clk);
    #1 exec_strobe = 1'b0;
  endtask

  task automatic acc(input logic v, input logic [AW-1:0] a, input logic ew,
                     input int k, input logic [7:0] salt, input string tag);
    @(negedge clk);
    acc_valid = v;
    acc_addr  = a;
    #5;
    chk({tag, " wr_en"}, wr_en === ew, wr_en, ew);
    if (ew) begin
      chk({tag, " wr_addr"}, wr_addr === a, wr_addr, a);
      chk({tag, " wr_data"}, wr_data === wv(salt, k), wr_data, wv(salt, k));
    end
  endtask

  task automatic chk_ready(input logic e, input string tag);
    @(negedge clk);
    acc_valid = 1'b0;
    #5 chk({tag, " ready"}, ready === e, ready, e);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; exec_strobe = 1'b0; acc_valid = 1'b0; acc_addr = '0;
    stage('0, '0, 8'h00);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R1 reset state, R7 no write while idle
    chk_ready(1'b1, "R1");
    acc(1'b1, 16'd0, 1'b0, 0, 8'h00, "R1_idle_access");

    // Table: R2 R3 write only at head, in order; R7 address 15 after completion
    stage(16'd10, 4'd4, 8'h31);
    go();
    chk_ready(1'b0, "R4_fall");
    for (int i = 0; i < 12; i++) begin
      acc(VEC[i][21], VEC[i][20:5], VEC[i][4], int'(VEC[i][3:0]), 8'h31,
          VEC[i][4] ? "R2_vec" : "R3_vec");
      if (i == 10) begin
        #4 chk("R4_rise", ready === 1'b0, ready, 0);
      end
    end
    chk_ready(1'b1, "R4_after");

    // R5 single-word burst
    stage(16'h0040, 4'd0, 8'h52);
    go();
    acc(1'b1, 16'h0040, 1'b1, 0, 8'h52, "R5_single");
    chk_ready(1'b1, "R5_single_done");
    acc(1'b1, 16'h0040, 1'b0, 0, 8'h52, "R7_repeat");

    // R8 wrap modulo 2^16
    stage(16'hFFFE, 4'd3, 8'h83);
    go();
    acc(1'b1, 16'hFFFE, 1'b1, 0, 8'h83, "R8_a");
    acc(1'b1, 16'hFFFF, 1'b1, 1, 8'h83, "R8_b");
    acc(1'b1, 16'h0000, 1'b1, 2, 8'h83, "R8_c");
    acc(1'b1, 16'h0001, 1'b1, 3, 8'h83, "R8_d");
    chk_ready(1'b1, "R8_done");

    // R6 exec while busy ignored; R9 invalid access
    stage(16'h0100, 4'd1, 8'h64);
    go();
    stage(16'h0200, 4'd2, 8'h99);
    go();
    chk_ready(1'b0, "R6_still_busy");
    acc(1'b1, 16'h0200, 1'b0, 0, 8'h99, "R6_new_addr");
    acc(1'b1, 16'h0100, 1'b1, 0, 8'h64, "R6_old_word");
    acc(1'b0, 16'h0101, 1'b0, 0, 8'h64, "R9_invalid");
    // final write coincides with a new execute
    stage(16'h0300, 4'd0, 8'h77);
    @(negedge clk);
    exec_strobe = 1'b1; acc_valid = 1'b1; acc_addr = 16'h0101;
    #5;
    chk("R6_final wr_en", wr_en === 1'b1, wr_en, 1);
    chk("R6_final wr_data", wr_data === wv(8'h64, 1), wr_data, wv(8'h64, 1));
    @(posedge clk);
    #1 exec_strobe = 1'b0;
    chk_ready(1'b1, "R6_done");
    acc(1'b1, 16'h0300, 1'b0, 0, 8'h77, "R6_no_new_burst");

    // R5 full 16-word burst, R3 out-of-order first access
    stage(16'h2000, 4'd15, 8'hC4);
    go();
    acc(1'b1, 16'h200F, 1'b0, 0, 8'hC4, "R3_skip_last");
    for (int k = 0; k < 16; k++) begin
      acc(1'b1, 16'h2000 + 16'(k), 1'b1, k, 8'hC4, "R5_full");
      if (k == 14) begin
        #4 chk("R5_full_busy", ready === 1'b0, ready, 0);
      end
    end
    chk_ready(1'b1, "R5_full_done");
    acc(1'b1, 16'h2010, 1'b0, 0, 8'hC4, "R7_beyond");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule